// File: doc/BRIEF.md
# Neighbour-Shared Banked Data Memory

This block is a 64 KB data store that four neighbouring masters reach through four access ports. The ports are named after the direction each faces: north, south, east and west. The west port belongs to the tile's own processor. The store is split into eight independent banks. Each port presents a single-cycle read or write with a byte address, write data and a write enable. In the same cycle it learns from its grant whether the access took place.

Ports that address different banks are all served in the same cycle. When two or more ports address one bank, a round-robin arbiter owned by that bank picks exactly one of them. The losers hold their request until they are granted. A port can be removed by parameter for tiles at the edge of an array. A removed port can neither request nor win.

Top module: `nbr_bank_mem`

## Requirements
- R1: Addresses are byte addresses of 32-bit words. Bits [15:13] select one of 8 banks, bits [12:2] select one of 2048 words in that bank, and bits [1:0] are ignored.
- R2: A granted write stores its data in the addressed word. A granted read presents that word on the port's rdata_o in the cycle after the grant.
- R3: In any cycle at most one port is granted per bank.
- R4: Grant is combinational, in the request cycle. Every eligible requester that is alone on its bank is granted in that cycle, so ports on distinct banks are all served together.
- R5: A port is granted only while it requests. A bank with at least one eligible requester grants one of them.
- R6: Port index p is bit p of every per-port vector: 0 north, 1 south, 2 east, 3 west (the local processor). Each bank holds its own round-robin pointer. After reset the priority order is 0,1,2,3. After each grant, the port following the winner becomes first in line.
- R7: A port that keeps requesting the same bank loses at most three consecutive cycles.
- R8: A port whose PORT_PRESENT bit is 0 is never granted, and its writes do not change memory.
- R9: A write that loses arbitration does not change memory.
- R10: After reset, every rdata_o is zero, and gnt_o is zero while nothing requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Per-port access request |
| we_i | input | 4 | Per-port write enable (0 = read) |
| addr_i | input | 4x16 | Per-port byte address |
| wdata_i | input | 4x32 | Per-port write data |
| gnt_o | output | 4 | Per-port grant, same cycle as the request |
| rdata_o | output | 4x32 | Per-port read data, valid the cycle after a granted read |

## Verification
The hardest case to reach is a held collision: a port must keep losing on one bank while the pointer walks past it, and only round-robin order decides when it wins. Vectors keep all four ports on one bank for consecutive cycles and keep two ports colliding for several cycles, with the grant order worked out in advance. Writes issued by the losers are then read back to show they left nothing behind. A second instance with the north port removed shows that its write attempts leave a word untouched.

// File: rtl/nbr_mem_pkg.sv
package nbr_mem_pkg;
  localparam int unsigned PORT_CNT  = 4;
  localparam int unsigned ADDR_BITS = 16;
  localparam int unsigned DATA_BITS = 32;
  localparam int unsigned BANK_BITS = 3;

  typedef enum logic [1:0] {
    PORT_NORTH = 2'd0,
    PORT_SOUTH = 2'd1,
    PORT_EAST  = 2'd2,
    PORT_WEST  = 2'd3
  } port_e;

  // processor of the own tile sits on this side
  localparam port_e LOCAL_PORT = PORT_WEST;
endpackage

// File: rtl/nbr_mem_rr_arb.sv
module nbr_mem_rr_arb #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] ptr_q, ptr_d;

  // first requester at or after the pointer, circularly
  always_comb begin
    gnt_o = '0;
    ptr_d = ptr_q;
    for (int k = 0; k < int'(N); k++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + k) % N;
      if (req_i[idx] && (gnt_o == '0)) begin
        gnt_o[idx] = 1'b1;
        ptr_d      = IW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/nbr_mem_bank.sv
module nbr_mem_bank #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 32,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0]         we_i,
  input  logic [N-1:0][AW-1:0] woff_i,
  input  logic [N-1:0][DW-1:0] wdata_i,
  output logic [N-1:0]         gnt_o,
  output logic [DW-1:0]        rdata_o
);
  logic          sel_we;
  logic [AW-1:0] sel_off;
  logic [DW-1:0] sel_wd;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] mem [DEPTH];

  nbr_mem_rr_arb #(.N(N)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .gnt_o (gnt_o)
  );

  // one-hot grant, so an AND-OR mux suffices
  always_comb begin
    sel_we  = 1'b0;
    sel_off = '0;
    sel_wd  = '0;
    for (int p = 0; p < int'(N); p++) begin
      if (gnt_o[p]) begin
        sel_we  = sel_we  | we_i[p];
        sel_off = sel_off | woff_i[p];
        sel_wd  = sel_wd  | wdata_i[p];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if ((|gnt_o) && sel_we) mem[sel_off] <= sel_wd;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rdata_q <= '0;
    else if ((|gnt_o) && !sel_we) rdata_q <= mem[sel_off];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/nbr_bank_mem.sv
module nbr_bank_mem
  import nbr_mem_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = PORT_CNT,
  parameter int unsigned ADDR_W     = ADDR_BITS,
  parameter int unsigned DATA_W     = DATA_BITS,
  parameter int unsigned BANK_SEL_W = BANK_BITS,
  parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_PORTS-1:0]              req_i,
  input  logic [NUM_PORTS-1:0]              we_i,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0]  wdata_i,
  output logic [NUM_PORTS-1:0]              gnt_o,
  output logic [NUM_PORTS-1:0][DATA_W-1:0]  rdata_o
);
  localparam int unsigned NUM_BANKS = 1 << BANK_SEL_W;
  localparam int unsigned BYTE_W    = $clog2(DATA_W / 8);
  localparam int unsigned WORD_AW   = ADDR_W - BANK_SEL_W - BYTE_W;

  logic [NUM_PORTS-1:0][BANK_SEL_W-1:0] bank_sel;
  logic [NUM_PORTS-1:0][WORD_AW-1:0]    word_off;
  logic [NUM_PORTS-1:0]                 live_req;
  logic [NUM_PORTS-1:0]                 unused_byte_bits;
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0]  bank_req;
  logic [NUM_BANKS-1:0][NUM_PORTS-1:0]  bank_gnt;
  logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_rdata;
  logic [NUM_PORTS-1:0][BANK_SEL_W-1:0] rd_bank_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign bank_sel[p]         = addr_i[p][ADDR_W-1 -: BANK_SEL_W];
    assign word_off[p]         = addr_i[p][BYTE_W +: WORD_AW];
    assign live_req[p]         = req_i[p] & PORT_PRESENT[p];
    assign unused_byte_bits[p] = ^addr_i[p][BYTE_W-1:0];
  end

  always_comb begin
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        bank_req[b][p] = live_req[p] && (bank_sel[p] == BANK_SEL_W'(b));
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    nbr_mem_bank #(
      .N (NUM_PORTS),
      .AW(WORD_AW),
      .DW(DATA_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (bank_req[b]),
      .we_i   (we_i),
      .woff_i (word_off),
      .wdata_i(wdata_i),
      .gnt_o  (bank_gnt[b]),
      .rdata_o(bank_rdata[b])
    );
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      gnt_o = gnt_o | bank_gnt[b];
    end
  end

  // remember which bank answers each port's last read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bank_q <= '0;
    end else begin
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        if (gnt_o[p] && !we_i[p]) rd_bank_q[p] <= bank_sel[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      rdata_o[p] = bank_rdata[rd_bank_q[p]];
    end
  end
endmodule

// File: rtl/nbr_bank_mem_chk.sv
module nbr_bank_mem_chk #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned BANK_SEL_W = 3,
  parameter logic [NUM_PORTS-1:0] PORT_PRESENT = '1
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic [NUM_PORTS-1:0]             req_i,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_i,
  input logic [NUM_PORTS-1:0]             gnt_o
);
  localparam int unsigned CW = 8;

  logic [NUM_PORTS-1:0][BANK_SEL_W-1:0] bk;
  logic [NUM_PORTS-1:0][BANK_SEL_W-1:0] prev_bk_q;
  logic [NUM_PORTS-1:0][CW-1:0]         wait_q;
  logic clash, idle, lone_lost;
  logic unused_low;

  assign unused_low = ^addr_i;

  always_comb begin
    for (int p = 0; p < int'(NUM_PORTS); p++) bk[p] = addr_i[p][ADDR_W-1 -: BANK_SEL_W];
  end

  always_comb begin
    clash     = 1'b0;
    idle      = 1'b0;
    lone_lost = 1'b0;
    for (int p = 0; p < int'(NUM_PORTS); p++) begin
      logic hit, rival;
      hit   = 1'b0;
      rival = 1'b0;
      for (int q = 0; q < int'(NUM_PORTS); q++) begin
        if (q != p && gnt_o[p] && gnt_o[q] && bk[p] == bk[q]) clash = 1'b1;
        if (gnt_o[q] && bk[q] == bk[p]) hit = 1'b1;
        if (q != p && req_i[q] && PORT_PRESENT[q] && bk[q] == bk[p]) rival = 1'b1;
      end
      if (req_i[p] && PORT_PRESENT[p] && !hit) idle = 1'b1;
      if (req_i[p] && PORT_PRESENT[p] && !rival && !gnt_o[p]) lone_lost = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q    <= '0;
      prev_bk_q <= '0;
    end else begin
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        prev_bk_q[p] <= bk[p];
        if (req_i[p] && PORT_PRESENT[p] && !gnt_o[p]) begin
          if (wait_q[p] != '0 && bk[p] != prev_bk_q[p]) wait_q[p] <= CW'(1);
          else if (wait_q[p] != '1)                     wait_q[p] <= wait_q[p] + CW'(1);
        end else begin
          wait_q[p] <= '0;
        end
      end
    end
  end

  a_r3_one_winner_per_bank: assert property (@(posedge clk_i) disable iff (!rst_ni) !clash);
  a_r4_lone_requester_served: assert property (@(posedge clk_i) disable iff (!rst_ni) !lone_lost);
  a_r5_busy_bank_grants: assert property (@(posedge clk_i) disable iff (!rst_ni) !idle);
  a_r5_grant_needs_request: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~req_i) == '0);
  a_r8_absent_never_wins: assert property (@(posedge clk_i) disable iff (!rst_ni) (gnt_o & ~PORT_PRESENT) == '0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_wait
    a_r7_bounded_wait: assert property (@(posedge clk_i) disable iff (!rst_ni) wait_q[p] < CW'(NUM_PORTS));
  end
endmodule

bind nbr_bank_mem nbr_bank_mem_chk #(
  .NUM_PORTS   (NUM_PORTS),
  .ADDR_W      (ADDR_W),
  .BANK_SEL_W  (BANK_SEL_W),
  .PORT_PRESENT(PORT_PRESENT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .addr_i(addr_i),
  .gnt_o (gnt_o)
);

// File: tb/nbr_bank_mem_test.sv
`timescale 1ns/1ps
module nbr_bank_mem_test;
  localparam int NP = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NV = 13;

  // {req[3:0], we[3:0], bank W,E,S,N (3 bits each), expected gnt[3:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'b1111, 4'b1111, 3'd3, 3'd2, 3'd1, 3'd0, 4'b1111},
    {4'b1111, 4'b0000, 3'd3, 3'd2, 3'd1, 3'd0, 4'b1111},
    {4'b1111, 4'b1111, 3'd5, 3'd5, 3'd5, 3'd5, 4'b0001},
    {4'b1111, 4'b1111, 3'd5, 3'd5, 3'd5, 3'd5, 4'b0010},
    {4'b1111, 4'b1111, 3'd5, 3'd5, 3'd5, 3'd5, 4'b0100},
    {4'b1111, 4'b1111, 3'd5, 3'd5, 3'd5, 3'd5, 4'b1000},
    {4'b1001, 4'b0000, 3'd5, 3'd5, 3'd5, 3'd5, 4'b0001},
    {4'b1001, 4'b0000, 3'd5, 3'd5, 3'd5, 3'd5, 4'b1000},
    {4'b1111, 4'b0110, 3'd7, 3'd6, 3'd6, 3'd7, 4'b0011},
    {4'b1111, 4'b0110, 3'd7, 3'd6, 3'd6, 3'd7, 4'b1100},
    {4'b0000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 4'b0000},
    {4'b1000, 4'b1000, 3'd0, 3'd0, 3'd0, 3'd0, 4'b1000},
    {4'b1000, 4'b0000, 3'd0, 3'd0, 3'd0, 3'd0, 4'b1000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]         req, we, gnt;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][DW-1:0] wdata, rdata;
  logic [NP-1:0]         e_req, e_we, e_gnt;
  logic [NP-1:0][AW-1:0] e_addr;
  logic [NP-1:0][DW-1:0] e_wdata, e_rdata;

  nbr_bank_mem uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .gnt_o(gnt), .rdata_o(rdata)
  );

  nbr_bank_mem #(.PORT_PRESENT(4'b1110)) uut_edge (
    .clk_i(clk), .rst_ni(rst_n), .req_i(e_req), .we_i(e_we),
    .addr_i(e_addr), .wdata_i(e_wdata), .gnt_o(e_gnt), .rdata_o(e_rdata)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [31:0] model [int];

  function automatic logic [15:0] mk(int bank, int word, int lo);
    return {3'(bank), 11'(word), 2'(lo)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [NP-1:0]         pend;
    logic [NP-1:0][31:0]   pexp;
    int cnt [NP];
    req = '0; we = '0; addr = '0; wdata = '0;
    e_req = '0; e_we = '0; e_addr = '0; e_wdata = '0;
    pend = '0; pexp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    // R10 reset state
    chk(gnt == '0, "R10 gnt idle after reset", 32'(gnt), 0);
    chk(e_gnt == '0, "R10 edge gnt idle after reset", 32'(e_gnt), 0);
    for (int p = 0; p < NP; p++) begin
      chk(rdata[p] == '0, "R10 rdata zero after reset", rdata[p], 0);
      chk(e_rdata[p] == '0, "R10 edge rdata zero after reset", e_rdata[p], 0);
    end

    // vector table: R2 R3 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++)
        if (pend[p]) chk(rdata[p] == pexp[p], "R2 read data next cycle", rdata[p], pexp[p]);
      pend = '0;
      req = VEC[v][23:20];
      we  = VEC[v][19:16];
      for (int p = 0; p < NP; p++) begin
        addr[p]  = mk(int'(VEC[v][4+3*p +: 3]), p, 0);
        wdata[p] = {4'hA, 4'(p), 8'(v), 16'h5A5A};
      end
      #5;
      chk(gnt == VEC[v][3:0], "R5 R6 table grant pattern", 32'(gnt), 32'(VEC[v][3:0]));
      for (int p = 0; p < NP; p++) begin
        if (VEC[v][p]) begin
          int key;
          key = int'(VEC[v][4+3*p +: 3]) * 2048 + p;
          if (we[p]) model[key] = wdata[p];
          else if (model.exists(key)) begin
            pend[p] = 1'b1;
            pexp[p] = model[key];
          end
        end
      end
    end
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      if (pend[p]) chk(rdata[p] == pexp[p], "R2 read data next cycle", rdata[p], pexp[p]);
    req = '0;

    // R1 R4: distinct banks, same offset, byte bits ignored
    @(negedge clk);
    req = 4'b0011; we = 4'b0011;
    addr[0] = mk(1, 9, 3); wdata[0] = 32'h1111_AAAA;
    addr[1] = mk(2, 9, 0); wdata[1] = 32'h2222_BBBB;
    #5;
    chk(gnt == 4'b0011, "R4 distinct-bank writes both granted", 32'(gnt), 32'b0011);
    @(negedge clk);
    we = 4'b0000;
    addr[0] = mk(2, 9, 0);
    addr[1] = mk(1, 9, 2);
    #5;
    chk(gnt == 4'b0011, "R4 distinct-bank reads both granted", 32'(gnt), 32'b0011);
    @(negedge clk);
    req = '0;
    chk(rdata[0] == 32'h2222_BBBB, "R1 bank 2 word 9", rdata[0], 32'h2222_BBBB);
    chk(rdata[1] == 32'h1111_AAAA, "R1 byte bits ignored bank 1 word 9", rdata[1], 32'h1111_AAAA);

    // R9: losing write leaves no trace
    @(negedge clk);
    req = 4'b0011; we = 4'b0011;
    addr[0] = mk(3, 20, 0); wdata[0] = 32'hC0FF_EE00;
    addr[1] = mk(3, 20, 0); wdata[1] = 32'hDEAD_0001;
    #5;
    chk(gnt == 4'b0001, "R9 collision north wins", 32'(gnt), 32'b0001);
    @(negedge clk);
    req = 4'b0010; we = 4'b0000;
    #5;
    chk(gnt == 4'b0010, "R9 south read granted", 32'(gnt), 32'b0010);
    @(negedge clk);
    req = '0;
    chk(rdata[1] == 32'hC0FF_EE00, "R9 loser write dropped", rdata[1], 32'hC0FF_EE00);

    // R7 R3: four holders on bank 4, each served once in four cycles
    for (int p = 0; p < NP; p++) cnt[p] = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      req = 4'b1111; we = 4'b0000;
      for (int p = 0; p < NP; p++) addr[p] = mk(4, p, 0);
      #5;
      chk($countones(gnt) == 1, "R3 single winner on shared bank", 32'(gnt), 32'd1);
      for (int p = 0; p < NP; p++) if (gnt[p]) cnt[p]++;
    end
    @(negedge clk);
    req = '0;
    for (int p = 0; p < NP; p++)
      chk(cnt[p] == 1, "R7 every holder served", 32'(cnt[p]), 32'd1);

    // R6: two holders alternate
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      req = 4'b0101; we = 4'b0000;
      addr[0] = mk(4, 0, 0);
      addr[2] = mk(4, 2, 0);
      #5;
      chk(gnt == ((c % 2 == 0) ? 4'b0001 : 4'b0100), "R6 round-robin alternation",
          32'(gnt), (c % 2 == 0) ? 32'b0001 : 32'b0100);
    end
    @(negedge clk);
    req = '0;

    // R8: north absent on the edge instance
    e_req = 4'b0100; e_we = 4'b0100;
    e_addr[2] = mk(0, 7, 0); e_wdata[2] = 32'h0BAD_F00D;
    #5;
    chk(e_gnt == 4'b0100, "R8 present east write granted", 32'(e_gnt), 32'b0100);
    @(negedge clk);
    e_req = 4'b0001; e_we = 4'b0001;
    e_addr[0] = mk(0, 7, 0); e_wdata[0] = 32'h5555_5555;
    #5;
    chk(e_gnt == 4'b0000, "R8 absent port not granted", 32'(e_gnt), 0);
    @(negedge clk);
    e_req = 4'b0011; e_we = 4'b0000;
    e_addr[1] = mk(0, 1, 0);
    #5;
    chk(e_gnt == 4'b0010, "R8 present rival wins", 32'(e_gnt), 32'b0010);
    @(negedge clk);
    e_req = 4'b0100; e_we = 4'b0000;
    #5;
    chk(e_gnt == 4'b0100, "R8 east read granted", 32'(e_gnt), 32'b0100);
    @(negedge clk);
    e_req = '0;
    chk(e_rdata[2] == 32'h0BAD_F00D, "R8 absent write had no effect", e_rdata[2], 32'h0BAD_F00D);

    @(negedge clk);
    finish_run();
  end
endmodule